// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Result Registers

This unit serves the integer pipeline of a 32-bit RISC core. It runs four long-latency operations: signed multiply, unsigned multiply, signed divide and unsigned divide. Each result lands in two architectural registers, HI and LO. The core pulses `start` together with an operation code and two operands. `busy` stays high while the operation is in flight, and `done` pulses for one cycle when HI and LO have taken the result.

The divider is a restoring shifter that retires one quotient bit per clock. A parameter picks the multiplier. The default is a single-cycle array product. The other choice is a shift-add engine that retires one multiplier bit per clock. Both engines work on operand magnitudes, and the sign is restored when the result is written back. With that scheme, division by zero never traps and produces fixed values without a dedicated path. Two write strobes let the core load HI or LO directly from a data input, and both registers can always be read.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 2'b00 (signed multiply) treats both operands as two's complement, forms the 64-bit product, and writes bits 63:32 to HI and bits 31:0 to LO.
- R2: Operation code 2'b01 (unsigned multiply) forms the 64-bit product of the operands taken as unsigned values and splits it into HI and LO in the same way.
- R3: Operation code 2'b10 (signed divide) with a nonzero divisor writes the quotient, truncated toward zero, to LO and the remainder to HI. The remainder is zero or carries the sign of the dividend.
- R4: Operation code 2'b11 (unsigned divide) with a nonzero divisor writes the unsigned quotient to LO and the remainder to HI.
- R5: A signed divide by zero copies the dividend to HI. It writes 1 to LO if the dividend is negative, and 0xFFFFFFFF otherwise.
- R6: An unsigned divide by zero writes 0xFFFFFFFF to LO and copies the dividend to HI.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0, and nothing is signalled.
- R8: A cycle with `hi_wr` high loads `wr_data` into HI, and a cycle with `lo_wr` high loads `wr_data` into LO, from the next clock edge. A result written back in the same cycle takes precedence over a move.
- R9: A `start` pulse that arrives while `busy` is high is ignored. It changes neither the running operation's result nor its timing, and no further completion follows.
- R10: While `busy` is high and no move is applied, `hi_out` and `lo_out` keep the values they held before the operation began.
- R11: A divide accepted at clock edge 0 raises `busy` at that edge. At edge 32 it updates HI and LO, lowers `busy` and raises `done`, and `done` then stays high for exactly one cycle.
- R12: With the default multiplier, a multiply accepted at edge 0 completes at edge 1, with `done` high for one cycle and `busy` low again.
- R13: After reset, HI and LO are zero and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when `busy` is low |
| op | input | 2 | Operation code: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| hi_wr | input | 1 | Loads `wr_data` into HI |
| lo_wr | input | 1 | Loads `wr_data` into LO |
| wr_data | input | 32 | Data for HI/LO moves |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle pulse when HI/LO take a result |
| hi_out | output | 32 | Current HI value |
| lo_out | output | 32 | Current LO value |

## Verification
The case hardest to reach from the ports is a second `start` landing in the middle of a 32-cycle divide. A wrong design can either restart the engine or queue the multiply, and it then shows up as a changed result, a shifted completion edge or a second `done` pulse. The stimulus first loads known values into HI and LO with the move strobes, then launches an unsigned divide. Five cycles in, it pulses `start` with a multiply whose product differs from the quotient. It checks that HI and LO hold their old values during the run, that completion comes at exactly edge 32 with the divide's result, and that no later completion follows. The sign corner cases are divide by zero with negative, zero and positive dividends, and the most negative value divided by minus one. They come from a vector table whose expected values are worked out with 64-bit arithmetic in the bench.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   typedef enum logic [1:0] {
      MD_MUL_S = 2'b00,
      MD_MUL_U = 2'b01,
      MD_DIV_S = 2'b10,
      MD_DIV_U = 2'b11
   } md_op_e;

   function automatic logic op_is_div(input logic [1:0] code);
      return code[1];
   endfunction

   function automatic logic op_is_signed(input logic [1:0] code);
      return ~code[0];
   endfunction
endpackage

// File: rtl/muldiv_mul.sv
// Unsigned magnitude multiplier; ITERATIVE selects array or shift-add form.
module muldiv_mul #(
   parameter int XLEN      = 32,
   parameter bit ITERATIVE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [XLEN-1:0]   mag_a,
   input  logic [XLEN-1:0]   mag_b,
   output logic              fin,
   output logic [2*XLEN-1:0] prod
);
   localparam int PW = 2 * XLEN;
   localparam int CW = $clog2(XLEN);
   localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

   generate
      if (!ITERATIVE) begin : g_array
         logic [XLEN-1:0] a_q, b_q;
         logic            run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_q   <= '0;
               b_q   <= '0;
               run_q <= 1'b0;
            end else begin
               run_q <= go;
               if (go) begin
                  a_q <= mag_a;
                  b_q <= mag_b;
               end
            end
         end

         assign fin  = run_q;
         assign prod = PW'(a_q) * PW'(b_q);

         p_mul_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
            go |=> fin);
      end else begin : g_shift_add
         logic [PW-1:0]   p_q;
         logic [XLEN-1:0] mcand_q;
         logic [CW-1:0]   cnt_q;
         logic            run_q;
         logic [XLEN:0]   upper_sum;
         logic [PW-1:0]   p_nx;

         always_comb begin
            upper_sum = {1'b0, p_q[PW-1:XLEN]} + (p_q[0] ? {1'b0, mcand_q} : '0);
            p_nx      = {upper_sum, p_q[XLEN-1:1]};
         end

         assign fin  = run_q && (cnt_q == LAST);
         assign prod = p_nx;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               p_q     <= '0;
               mcand_q <= '0;
               cnt_q   <= '0;
               run_q   <= 1'b0;
            end else if (go) begin
               p_q     <= {{XLEN{1'b0}}, mag_b};
               mcand_q <= mag_a;
               cnt_q   <= '0;
               run_q   <= 1'b1;
            end else if (run_q) begin
               p_q   <= p_nx;
               cnt_q <= cnt_q + 1'b1;
               if (fin) run_q <= 1'b0;
            end
         end

         p_mul_iter_stops_r12: assert property (@(posedge clk) disable iff (!rst_n)
            fin |=> !run_q);
      end
   endgenerate
endmodule

// File: rtl/muldiv_div.sv
// Restoring divider on unsigned magnitudes, one quotient bit per clock.
module muldiv_div #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [XLEN-1:0] mag_n,
   input  logic [XLEN-1:0] mag_d,
   output logic            fin,
   output logic [XLEN-1:0] quo,
   output logic [XLEN-1:0] rem
);
   localparam int CW = $clog2(XLEN);
   localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

   logic [XLEN-1:0] rem_q, quo_q, dvs_q;
   logic [CW-1:0]   cnt_q;
   logic            run_q;
   logic [XLEN:0]   shifted, trial;
   logic            take;
   logic [XLEN-1:0] rem_nx, quo_nx;

   always_comb begin
      shifted = {rem_q, quo_q[XLEN-1]};
      trial   = shifted - {1'b0, dvs_q};
      take    = ~trial[XLEN];
      rem_nx  = take ? trial[XLEN-1:0] : shifted[XLEN-1:0];
      quo_nx  = {quo_q[XLEN-2:0], take};
   end

   assign fin = run_q && (cnt_q == LAST);
   assign quo = quo_nx;
   assign rem = rem_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dvs_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (go) begin
         rem_q <= '0;
         quo_q <= mag_n;
         dvs_q <= mag_d;
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (run_q) begin
         rem_q <= rem_nx;
         quo_q <= quo_nx;
         cnt_q <= cnt_q + 1'b1;
         if (fin) run_q <= 1'b0;
      end
   end

   // R6/R5: a zero divisor must yield an all-ones quotient magnitude
   p_div_zero_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && dvs_q == '0) |-> (quo == '1));

   p_div_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !run_q);
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
   parameter int XLEN          = 32,
   parameter bit MUL_ITERATIVE = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [1:0]      op,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   input  logic            hi_wr,
   input  logic            lo_wr,
   input  logic [XLEN-1:0] wr_data,
   output logic            busy,
   output logic            done,
   output logic [XLEN-1:0] hi_out,
   output logic [XLEN-1:0] lo_out
);
   import muldiv_pkg::*;

   localparam int PW = 2 * XLEN;

   generate
      if (XLEN < 4 || (XLEN % 2) != 0) begin : g_bad_width
         $error("muldiv_unit: XLEN must be even and at least 4");
      end
   endgenerate

   logic            busy_q, done_q;
   logic [XLEN-1:0] hi_q, lo_q;
   logic            neg_main_q, neg_rem_q;

   logic            accept, sgn;
   logic [XLEN-1:0] mag_a, mag_b;
   logic            mul_fin, div_fin, fin_any;
   logic [PW-1:0]   mul_prod, mul_signed;
   logic [XLEN-1:0] div_quo, div_rem;
   logic [XLEN-1:0] res_hi, res_lo;

   assign accept = start && !busy_q;
   assign sgn    = op_is_signed(op);
   assign mag_a  = (sgn && src_a[XLEN-1]) ? (~src_a + 1'b1) : src_a;
   assign mag_b  = (sgn && src_b[XLEN-1]) ? (~src_b + 1'b1) : src_b;

   muldiv_mul #(.XLEN(XLEN), .ITERATIVE(MUL_ITERATIVE)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (accept && !op_is_div(op)),
      .mag_a (mag_a),
      .mag_b (mag_b),
      .fin   (mul_fin),
      .prod  (mul_prod)
   );

   muldiv_div #(.XLEN(XLEN)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (accept && op_is_div(op)),
      .mag_n (mag_a),
      .mag_d (mag_b),
      .fin   (div_fin),
      .quo   (div_quo),
      .rem   (div_rem)
   );

   assign fin_any = mul_fin || div_fin;

   // Sign restoration: product/quotient negated on differing signs,
   // remainder follows the dividend. Zero divisor falls out of the same rule.
   always_comb begin
      mul_signed = neg_main_q ? (~mul_prod + 1'b1) : mul_prod;
      if (div_fin) begin
         res_lo = neg_main_q ? (~div_quo + 1'b1) : div_quo;
         res_hi = neg_rem_q  ? (~div_rem + 1'b1) : div_rem;
      end else begin
         res_lo = mul_signed[XLEN-1:0];
         res_hi = mul_signed[PW-1:XLEN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
         hi_q       <= '0;
         lo_q       <= '0;
         neg_main_q <= 1'b0;
         neg_rem_q  <= 1'b0;
      end else begin
         done_q <= fin_any;
         if (accept) begin
            busy_q     <= 1'b1;
            neg_main_q <= sgn && (src_a[XLEN-1] ^ src_b[XLEN-1]);
            neg_rem_q  <= sgn && src_a[XLEN-1];
         end else if (fin_any) begin
            busy_q <= 1'b0;
         end
         if (fin_any) begin
            hi_q <= res_hi;
            lo_q <= res_lo;
         end else begin
            if (hi_wr) hi_q <= wr_data;
            if (lo_wr) lo_q <= wr_data;
         end
      end
   end

   assign busy   = busy_q;
   assign done   = done_q;
   assign hi_out = hi_q;
   assign lo_out = lo_q;

   p_busy_falls_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);

   p_done_needs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(busy_q));

   p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fin_any) |=> busy_q);

   p_hi_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fin_any && !hi_wr) |=> $stable(hi_q));

   p_lo_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fin_any && !lo_wr) |=> $stable(lo_q));
endmodule

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [31:0] src_a = '0, src_b = '0, wr_data = '0;
   logic        hi_wr = 1'b0, lo_wr = 1'b0;
   logic        busy, done;
   logic [31:0] hi_out, lo_out;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   muldiv_unit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .src_a(src_a), .src_b(src_b), .hi_wr(hi_wr), .lo_wr(lo_wr),
      .wr_data(wr_data), .busy(busy), .done(done),
      .hi_out(hi_out), .lo_out(lo_out)
   );

   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] a;
      logic [31:0] b;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 32'h0000_0003, 32'hFFFF_FFFB},
      '{2'b00, 32'h8000_0000, 32'h8000_0000},
      '{2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      '{2'b00, 32'h1234_5678, 32'h9ABC_DEF0},
      '{2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      '{2'b01, 32'h1234_5678, 32'h9ABC_DEF0},
      '{2'b10, 32'h0000_0007, 32'h0000_0002},
      '{2'b10, 32'hFFFF_FFF9, 32'h0000_0002},
      '{2'b10, 32'h0000_0007, 32'hFFFF_FFFE},
      '{2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE},
      '{2'b11, 32'hFFFF_FFFF, 32'h0000_0003},
      '{2'b11, 32'h0000_0064, 32'h0000_0007},
      '{2'b10, 32'h0000_0005, 32'h0000_0000},
      '{2'b10, 32'hFFFF_FFFB, 32'h0000_0000},
      '{2'b10, 32'h0000_0000, 32'h0000_0000},
      '{2'b11, 32'h8000_0000, 32'h0000_0000},
      '{2'b11, 32'h0000_0000, 32'h0000_0000},
      '{2'b10, 32'h8000_0000, 32'hFFFF_FFFF},
      '{2'b10, 32'h8000_0000, 32'h0000_0001}
   };

   task automatic check32(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [1:0] o, input logic [31:0] a,
                                    input logic [31:0] b);
      case (o)
         2'b00: return "R1";
         2'b01: return "R2";
         2'b10: begin
            if (b == 0) return "R5";
            if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R7";
            return "R3";
         end
         default: return (b == 0) ? "R6" : "R4";
      endcase
   endfunction

   task automatic expect_of(input logic [1:0] o, input logic [31:0] a,
                            input logic [31:0] b,
                            output logic [31:0] eh, output logic [31:0] el);
      longint sa, sb, q, r;
      longint unsigned up;
      logic [63:0] p;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      case (o)
         2'b00: begin p = 64'(sa * sb); eh = p[63:32]; el = p[31:0]; end
         2'b01: begin up = {32'd0, a} * {32'd0, b}; p = up; eh = p[63:32]; el = p[31:0]; end
         2'b10: begin
            if (b == 0) begin eh = a; el = a[31] ? 32'h1 : 32'hFFFF_FFFF; end
            else begin q = sa / sb; r = sa % sb; el = q[31:0]; eh = r[31:0]; end
         end
         default: begin
            if (b == 0) begin eh = a; el = 32'hFFFF_FFFF; end
            else begin el = a / b; eh = a % b; end
         end
      endcase
   endtask

   // Launch at edge 0, return number of edges until done seen (sampled at negedge).
   task automatic launch(input logic [1:0] o, input logic [31:0] a,
                         input logic [31:0] b, output int lat);
      @(negedge clk);
      start = 1'b1; op = o; src_a = a; src_b = b;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R11 watchdog: actual=hung expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int lat;
      logic [31:0] eh, el;
      string t;

      repeat (3) @(posedge clk);
      @(negedge clk);
      // R13: reset state
      check32("R13", "hi after reset", hi_out, 32'h0);
      check32("R13", "lo after reset", lo_out, 32'h0);
      check32("R13", "busy after reset", {31'd0, busy}, 32'h0);
      check32("R13", "done after reset", {31'd0, done}, 32'h0);
      rst_n = 1'b1;

      foreach (VECS[i]) begin
         t = tag_of(VECS[i].op, VECS[i].a, VECS[i].b);
         expect_of(VECS[i].op, VECS[i].a, VECS[i].b, eh, el);
         launch(VECS[i].op, VECS[i].a, VECS[i].b, lat);
         check32(t, $sformatf("vec %0d hi", i), hi_out, eh);
         check32(t, $sformatf("vec %0d lo", i), lo_out, el);
         if (VECS[i].op[1])
            check32("R11", $sformatf("vec %0d divide latency", i), lat, 32);
         else
            check32("R12", $sformatf("vec %0d multiply latency", i), lat, 1);
         check32(VECS[i].op[1] ? "R11" : "R12", "busy low at done", {31'd0, busy}, 0);
         @(negedge clk);
         check32(VECS[i].op[1] ? "R11" : "R12", "done one cycle", {31'd0, done}, 0);
      end

      // R8: moves into HI and LO
      @(negedge clk);
      hi_wr = 1'b1; wr_data = 32'hA5A5_0F0F;
      @(negedge clk);
      hi_wr = 1'b0; lo_wr = 1'b1; wr_data = 32'h1357_9BDF;
      @(negedge clk);
      lo_wr = 1'b0;
      check32("R8", "move to hi", hi_out, 32'hA5A5_0F0F);
      check32("R8", "move to lo", lo_out, 32'h1357_9BDF);

      // R9/R10: start while busy ignored, old values visible during run
      start = 1'b1; op = 2'b11; src_a = 32'd100; src_b = 32'd7;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      check32("R10", "hi held at run start", hi_out, 32'hA5A5_0F0F);
      check32("R11", "busy during divide", {31'd0, busy}, 1);
      repeat (5) begin @(posedge clk); lat++; @(negedge clk); end
      start = 1'b1; op = 2'b00; src_a = 32'd3; src_b = 32'd3;
      @(posedge clk); lat++;
      @(negedge clk);
      start = 1'b0;
      check32("R10", "hi held mid run", hi_out, 32'hA5A5_0F0F);
      check32("R10", "lo held mid run", lo_out, 32'h1357_9BDF);
      check32("R9", "still busy after stray start", {31'd0, busy}, 1);
      while (!done && lat < 100) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
      end
      check32("R9", "divide latency unchanged", lat, 32);
      check32("R9", "divide quotient kept", lo_out, 32'd14);
      check32("R9", "divide remainder kept", hi_out, 32'd2);
      repeat (4) begin
         @(negedge clk);
         check32("R9", "no extra completion", {31'd0, done}, 0);
      end
      check32("R9", "lo not overwritten by stray op", lo_out, 32'd14);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule